// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block sits between a serial receiver front end and a register read port. It holds up to four received bytes in arrival order. The read side sees the oldest byte and removes it with a one-cycle pop strobe. The block reports whether data is waiting and whether the queue is full. It drives an accept signal back to the front end for flow control. Reception is turned on and off by a two-bit receive command, and a receiver-reset command empties the queue.

A line monitor reports break conditions. Each break event latches a delta-break flag and inserts a 0x00 byte into the queue. A normal byte is refused when the queue is full, but a break byte is never lost. When there is no room, it overwrites the newest entry, so the software always sees that a break happened. The command decoder clears the delta-break flag with a separate strobe.

Top module: `rxq_holding`

## Requirements
- R1: The queue holds up to 4 bytes in first-in first-out order. While the queue is non-empty, `pop_data` shows the oldest entry, and a `pop` removes that entry.
- R2: `rdy` is high exactly when at least one byte is held. `full` is high exactly when 4 bytes are held. Both reflect an operation from the clock cycle after it.
- R3: While the queue is empty, `pop_data` reads 0x00, and a `pop` changes no state.
- R4: `accept` is high only when reception is enabled and `full` is low. A byte offered with `byte_vld` is stored only when `accept` is high in that cycle; otherwise it is dropped.
- R5: `rx_cmd` encoding: 2'b01 enables reception and 2'b10 disables it. 2'b00 and 2'b11 leave the enable unchanged. Reception is disabled after reset.
- R6: A `brk_evt` stores a 0x00 byte whether or not reception is enabled. When 4 bytes are held and there is no pop, the new byte replaces the newest entry and the count stays at 4. A normal byte offered in the same cycle is dropped.
- R7: `brk_evt` sets `brk_flag` and `brk_clr` clears it. When both arrive in the same cycle, the clear wins.
- R8: `rx_reset` empties the queue and disables reception. It overrides any push, pop or `rx_cmd` in the same cycle and leaves `brk_flag` unchanged.
- R9: A push and a pop in the same cycle leave the count unchanged and keep the order. The pop is applied first, so a break arriving with a pop on a full queue appends its byte and does not overwrite.
- R10: After reset the queue is empty, reception is disabled, `brk_flag` is low and `accept` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| byte_vld | input | 1 | Front end offers a received byte |
| byte_data | input | 8 | Received byte |
| brk_evt | input | 1 | Line monitor reports a break |
| rx_cmd | input | 2 | Receive enable command (01 on, 10 off) |
| rx_reset | input | 1 | Receiver-reset command strobe |
| brk_clr | input | 1 | Clear strobe for the delta-break flag |
| pop | input | 1 | Read port removes the oldest byte |
| pop_data | output | 8 | Oldest byte, or 0x00 when empty |
| rdy | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |
| accept | output | 1 | Front end may deliver a byte |
| brk_flag | output | 1 | Delta-break flag |

## Verification
The hardest case to reach is a break overwriting the newest entry. The queue must first be filled to four through the normal path while reception is enabled. A break must then arrive in a cycle with no pop, and the overwritten slot only becomes visible once the three older bytes are drained. The stimulus builds this up on purpose and then repeats the same fill with a pop in the break cycle, which must append instead of overwrite. A long random phase then mixes pops, breaks and bytes on full and nearly full queues, and adds occasional receiver resets. A behavioural queue model is compared against the outputs on every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    RXC_HOLD = 2'b00,
    RXC_ON   = 2'b01,
    RXC_OFF  = 2'b10,
    RXC_RSVD = 2'b11
  } rx_cmd_e;
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_cmd,
  input  logic       rx_reset,
  input  logic       q_full,
  output logic       rx_on,
  output logic       accept
);
  logic on_q, on_nxt, on_en;

  always_comb begin
    on_nxt = on_q;
    if (rx_reset) begin
      on_nxt = 1'b0;
    end else begin
      case (rx_cmd_e'(rx_cmd))
        RXC_ON:  on_nxt = 1'b1;
        RXC_OFF: on_nxt = 1'b0;
        default: on_nxt = on_q;
      endcase
    end
    on_en = (on_nxt != on_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     on_q <= 1'b0;
    else if (on_en) on_q <= on_nxt;
  end

  assign rx_on  = on_q;
  assign accept = on_q & ~q_full;

  // R8: receiver reset leaves reception disabled
  a_r8_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> !rx_on);
  // R5: enable command takes effect next cycle
  a_r5_cmd_on: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cmd == 2'b01 && !rx_reset) |=> rx_on);
  // R5: reserved and hold codes keep the enable
  a_r5_cmd_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_cmd == 2'b00 || rx_cmd == 2'b11) && !rx_reset) |=> $stable(rx_on));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          brk,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head_data,
  output logic          rdy,
  output logic          full
);
  // DEPTH must be a power of two: slot indices wrap by truncation
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] rd_q, rd_nxt, wr_slot;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_ap;
  logic             do_pop, at_cap, wr_any, upd_en;
  logic [DW-1:0]    wr_data;
  logic [DW-1:0]    slot_view [DEPTH];

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    cnt_ap  = cnt_q - CNT_W'(do_pop);
    at_cap  = (cnt_ap == CNT_W'(DEPTH));
    wr_any  = !flush && (brk || push);
    wr_data = brk ? '0 : push_data;
    wr_slot = at_cap ? (rd_q + PTR_W'(DEPTH - 1)) : (rd_q + PTR_W'(cnt_q));
    rd_nxt  = rd_q + PTR_W'(do_pop);
    cnt_nxt = cnt_ap + CNT_W'(wr_any && !at_cap);
    if (flush) begin
      rd_nxt  = '0;
      cnt_nxt = '0;
    end
    upd_en = flush || do_pop || wr_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic          we;
    logic [DW-1:0] data_q;
    assign we = wr_any && (wr_slot == PTR_W'(s));
    always_ff @(posedge clk) begin
      if (we) data_q <= wr_data;
    end
    assign slot_view[s] = data_q;
  end

  assign rdy       = (cnt_q != '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_data = rdy ? slot_view[rd_q] : '0;

  // R1: occupancy never exceeds the depth
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R6: a break on a full queue without pop keeps it full
  a_r6_brk_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (full && brk && !pop && !flush) |=> full);
  // R3: pop on an empty queue leaves it empty
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && pop && !push && !brk && !flush) |=> !rdy);
  // R9: simultaneous push and pop keep the count
  a_r9_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && pop && (push || brk) && !flush) |=> $stable(cnt_q));
endmodule

// File: rtl/rxq_dbrk.sv
module rxq_dbrk (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_nxt, flag_en;

  always_comb begin
    flag_nxt = flag_q;
    if (clr)      flag_nxt = 1'b0;
    else if (brk) flag_nxt = 1'b1;
    flag_en = (flag_nxt != flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_nxt;
  end

  assign flag = flag_q;

  // R7: clear wins over a simultaneous break
  a_r7_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
  // R7: break without clear raises the flag
  a_r7_brk_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !clr) |=> flag);
endmodule

// File: rtl/rxq_holding.sv
module rxq_holding #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          brk_evt,
  input  logic [1:0]    rx_cmd,
  input  logic          rx_reset,
  input  logic          brk_clr,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          rdy,
  output logic          full,
  output logic          accept,
  output logic          brk_flag
);
  logic rst_sync_n, rx_on, q_full, norm_push;

  rxq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  rxq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .rx_cmd(rx_cmd), .rx_reset(rx_reset),
    .q_full(q_full), .rx_on(rx_on), .accept(accept));

  // break has priority over a normal byte in the same cycle
  assign norm_push = byte_vld && accept && !brk_evt;

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .push(norm_push), .push_data(byte_data),
    .brk(brk_evt), .pop(pop), .flush(rx_reset), .head_data(pop_data),
    .rdy(rdy), .full(q_full));

  rxq_dbrk u_dbrk (
    .clk(clk), .rst_n(rst_sync_n), .brk(brk_evt), .clr(brk_clr), .flag(brk_flag));

  assign full = q_full;

  // R4: no acceptance while the queue is full
  a_r4_no_accept_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full |-> !accept);
  // R8: receiver reset empties the queue
  a_r8_reset_empties: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_reset |=> (!rdy && !accept));
  // R4: a byte offered while disabled is not stored into an empty queue
  a_r4_disabled_drop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rx_on && !rdy && !brk_evt && !rx_reset) |=> !rdy);
endmodule

// File: tb/rxq_holding_tb.sv
`timescale 1ns/1ps
module rxq_holding_tb;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_vld, brk_evt, rx_reset, brk_clr, pop;
  logic [7:0] byte_data;
  logic [1:0] rx_cmd;
  logic [7:0] pop_data;
  logic       rdy, full, accept, brk_flag;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string cur_tag = "R10";

  logic [7:0] mq[$];
  bit         m_on   = 0;
  bit         m_flag = 0;

  always #2.5 clk = ~clk;

  rxq_holding #(.DEPTH(DEPTH), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .brk_evt(brk_evt), .rx_cmd(rx_cmd), .rx_reset(rx_reset), .brk_clr(brk_clr),
    .pop(pop), .pop_data(pop_data), .rdy(rdy), .full(full), .accept(accept),
    .brk_flag(brk_flag));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int sz = mq.size();
    chk(cur_tag == "" ? "R1" : cur_tag, "pop_data(R1)", pop_data, sz > 0 ? mq[0] : 0);
    chk(cur_tag, "rdy(R2)", rdy, sz > 0);
    chk(cur_tag, "full(R2)", full, sz == DEPTH);
    chk(cur_tag, "accept(R4)", accept, m_on && sz < DEPTH);
    chk(cur_tag, "brk_flag(R7)", brk_flag, m_flag);
  endtask

  task automatic model(input bit p, input bit b, input bit v, input logic [7:0] d,
                       input logic [1:0] c, input bit rr, input bit cl);
    bit acc = m_on && mq.size() < DEPTH;
    if (rr) begin
      mq.delete();
      m_on = 0;
    end else begin
      if (p && mq.size() > 0) void'(mq.pop_front());
      if (b) begin
        if (mq.size() == DEPTH) mq[DEPTH-1] = 8'h00;
        else mq.push_back(8'h00);
      end else if (v && acc) begin
        mq.push_back(d);
      end
      if (c == 2'b01) m_on = 1;
      else if (c == 2'b10) m_on = 0;
    end
    if (cl) m_flag = 0;
    else if (b) m_flag = 1;
  endtask

  task automatic cyc(input bit p, input bit b, input bit v, input logic [7:0] d,
                     input logic [1:0] c, input bit rr, input bit cl);
    pop = p; brk_evt = b; byte_vld = v; byte_data = d;
    rx_cmd = c; rx_reset = rr; brk_clr = cl;
    @(posedge clk);
    model(p, b, v, d, c, rr, cl);
    @(negedge clk);
    pop = 0; brk_evt = 0; byte_vld = 0; byte_data = 0;
    rx_cmd = 0; rx_reset = 0; brk_clr = 0;
    compare_all();
  endtask

  task automatic push_b(input logic [7:0] d); cyc(0, 0, 1, d, 2'b00, 0, 0); endtask
  task automatic pop1();                     cyc(1, 0, 0, 0, 2'b00, 0, 0); endtask
  task automatic idle();                     cyc(0, 0, 0, 0, 2'b00, 0, 0); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pop = 0; brk_evt = 0; byte_vld = 0; byte_data = 0;
    rx_cmd = 0; rx_reset = 0; brk_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10", "rdy", rdy, 0);
    chk("R10", "full", full, 0);
    chk("R10", "accept", accept, 0);
    chk("R10", "brk_flag", brk_flag, 0);
    chk("R10", "pop_data", pop_data, 0);

    // R4: byte while disabled is dropped
    cur_tag = "R4";
    push_b(8'h11);
    chk("R4", "rdy after disabled byte", rdy, 0);

    // R5: command encodings
    cur_tag = "R5";
    cyc(0, 0, 0, 0, 2'b01, 0, 0);
    chk("R5", "accept after on", accept, 1);
    cyc(0, 0, 0, 0, 2'b11, 0, 0);
    chk("R5", "accept after reserved", accept, 1);
    cyc(0, 0, 0, 0, 2'b10, 0, 0);
    chk("R5", "accept after off", accept, 0);
    cyc(0, 0, 0, 0, 2'b00, 0, 0);
    chk("R5", "accept after hold", accept, 0);
    cyc(0, 0, 0, 0, 2'b01, 0, 0);

    // R1: FIFO order
    cur_tag = "R1";
    push_b(8'hA1); push_b(8'hA2); push_b(8'hA3);
    chk("R1", "head is oldest", pop_data, 8'hA1);
    // R9: push with pop keeps count
    cur_tag = "R9";
    cyc(1, 0, 1, 8'hA4, 2'b00, 0, 0);
    chk("R9", "head after push+pop", pop_data, 8'hA2);
    chk("R9", "not full after push+pop", full, 0);
    // R2: fill to four
    cur_tag = "R2";
    push_b(8'hA5);
    chk("R2", "full at four", full, 1);
    // R4: byte on full dropped
    cur_tag = "R4";
    push_b(8'h55);
    chk("R4", "accept on full", accept, 0);
    // R6: break on full overwrites newest
    cur_tag = "R6";
    cyc(0, 1, 1, 8'h66, 2'b00, 0, 0);
    chk("R6", "still full after break", full, 1);
    chk("R7", "flag after break", brk_flag, 1);
    pop1(); pop1(); pop1();
    chk("R6", "overwritten newest", pop_data, 8'h00);
    pop1();
    // R3: pop on empty
    cur_tag = "R3";
    chk("R3", "empty pop_data", pop_data, 0);
    pop1();
    chk("R3", "rdy after empty pop", rdy, 0);

    // R9: pop + break on full appends
    cur_tag = "R9";
    push_b(8'hB1); push_b(8'hB2); push_b(8'hB3); push_b(8'hB4);
    cyc(1, 1, 0, 0, 2'b00, 0, 0);
    chk("R9", "full after pop+break", full, 1);
    pop1(); pop1(); pop1();
    chk("R9", "break byte appended behind B4", pop_data, 8'h00);
    pop1();

    // R7: clear priority
    cur_tag = "R7";
    cyc(0, 1, 0, 0, 2'b00, 0, 1);
    chk("R7", "clr wins", brk_flag, 0);
    // R6: break while disabled still stores
    cur_tag = "R6";
    cyc(0, 0, 0, 0, 2'b10, 0, 0);
    cyc(0, 1, 0, 0, 2'b00, 0, 0);
    chk("R6", "break while off stored", rdy, 1);
    chk("R7", "flag set", brk_flag, 1);

    // R8: receiver reset overrides push, pop and enable
    cur_tag = "R8";
    cyc(0, 0, 0, 0, 2'b01, 0, 0);
    push_b(8'hC1);
    cyc(1, 0, 1, 8'hC2, 2'b01, 1, 0);
    chk("R8", "rdy after rx_reset", rdy, 0);
    chk("R8", "accept after rx_reset", accept, 0);
    chk("R8", "flag kept", brk_flag, 1);
    cyc(0, 0, 0, 0, 2'b00, 0, 1);

    // mixed random traffic
    cur_tag = "R1";
    for (int i = 0; i < 600; i++) begin
      bit         p  = $urandom_range(0, 2) == 0;
      bit         b  = $urandom_range(0, 9) == 0;
      bit         v  = $urandom_range(0, 1) == 1;
      logic [7:0] d  = 8'($urandom_range(1, 255));
      logic [1:0] c  = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
      bit         rr = $urandom_range(0, 59) == 0;
      bit         cl = $urandom_range(0, 11) == 0;
      cyc(p, b, v, d, c, rr, cl);
    end
    idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule